// File: doc/BRIEF.md
# Signed 40-bit Multiply-Accumulate Unit

This block keeps a single 40-bit signed accumulator and folds products of two 32-bit register operands into it. Each operation arrives with a valid strobe and a 3-bit operation code. Four codes pick a pair of 16-bit halves, one from each operand, for a 16x16 multiply. One code forms two half-word products at once: high half times high half, and low half times low half. One code forms a full 32x32 product. The last two codes move the accumulator to or from a pair of 32-bit registers.

Every product is signed and is sign-extended before it is added. The accumulator wraps modulo 2^40 and never saturates. The full-width multiply takes one extra cycle, and while it runs a busy flag turns away any new operation. A one-cycle done pulse marks the cycle in which the result of an operation can first be observed.

Top module: `mac40_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, `rd_lo` and `rd_hi` are cleared to zero, and `busy` and `done` are driven low.
- R2: Codes 0 to 3 are half-word multiply-accumulates. Code bit 1 selects the half of `src_a` (1 = bits 31:16, 0 = bits 15:0), and code bit 0 selects the half of `src_b` in the same way. The signed 32-bit product is sign-extended to 40 bits and added to the accumulator at the accepting edge.
- R3: Code 4 is the dual packed multiply-accumulate. The signed products src_a[31:16]*src_b[31:16] and src_a[15:0]*src_b[15:0] are each sign-extended to 40 bits, and both are added to the accumulator.
- R4: Code 5 forms the full signed 64-bit product of `src_a` and `src_b` and adds its low 40 bits to the accumulator. `busy` is high for exactly one cycle after the accepting edge, and the sum is written at the following edge.
- R5: Code 6 is move-in. It loads the accumulator with bits 39:32 = src_b[7:0] and bits 31:0 = src_a.
- R6: Code 7 is move-out. It sets `rd_lo` to accumulator bits 31:0 and `rd_hi` to accumulator bits 39:32 sign-extended to 32 bits, and it leaves the accumulator unchanged. `rd_lo` and `rd_hi` change on no other operation.
- R7: Accumulation wraps modulo 2^40 with no saturation and no overflow indication.
- R8: An `op_valid` presented while `busy` is high is ignored. The accumulator, `rd_lo` and `rd_hi` receive only the result of the operation already in progress.
- R9: In cycles with no accepted operation and no full multiply in progress, the accumulator, `rd_lo` and `rd_hi` hold their values and `done` stays low.
- R10: `done` is high for exactly one cycle, in the cycle that follows the edge at which an operation's result is written. For codes 0-4, 6 and 7 that is the accepting edge; for code 5 it is the edge one cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe; taken when `busy` is low |
| op_code | input | 3 | Operation selector (codes listed in R2-R6) |
| src_a | input | 32 | First operand; also the low register for move-in |
| src_b | input | 32 | Second operand; also the high register for move-in |
| busy | output | 1 | Full-width multiply in progress; new operations are refused |
| done | output | 1 | One-cycle pulse; the result of the operation is visible |
| rd_lo | output | 32 | Low register written by move-out |
| rd_hi | output | 32 | High register written by move-out, sign-extended |

## Verification
The hardest case to reach from the ports is an operation offered during the one busy cycle of a full-width multiply. The bench issues code 5 and holds the strobe high into the next cycle with a move-in whose operands would visibly overwrite the accumulator. It then reads the accumulator back through move-out. The accumulator holds no state that can be seen directly, so every arithmetic check follows the same pattern: a move-in sets a known base, one operation runs, and a move-out reads the result. The bench does this for each multiply code over every pair of a set of corner operands that includes sign boundaries, and it also runs an explicit wrap across the 40-bit limit.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

   typedef enum logic [2:0] {
      OPC_LL    = 3'd0,
      OPC_LH    = 3'd1,
      OPC_HL    = 3'd2,
      OPC_HH    = 3'd3,
      OPC_DUAL  = 3'd4,
      OPC_WIDE  = 3'd5,
      OPC_LOAD  = 3'd6,
      OPC_STORE = 3'd7
   } mac_opc_e;

   function automatic logic opc_is_half(input logic [2:0] c);
      return (c[2] == 1'b0);
   endfunction

endpackage

// File: rtl/mac40_lane_mult.sv
module mac40_lane_mult #(
   parameter int HALF_W = 16,
   parameter int ACC_W  = 40
) (
   input  logic [HALF_W-1:0] mul_x,
   input  logic [HALF_W-1:0] mul_y,
   output logic [ACC_W-1:0]  term
);
   localparam int PROD_W = 2 * HALF_W;
   localparam int EXT_W  = ACC_W - PROD_W;

   if (ACC_W <= PROD_W) begin : g_bad_width
      $error("mac40_lane_mult: ACC_W must exceed 2*HALF_W");
   end

   logic signed [HALF_W-1:0] sx;
   logic signed [HALF_W-1:0] sy;
   logic signed [PROD_W-1:0] prod;

   always_comb begin
      sx   = mul_x;
      sy   = mul_y;
      prod = PROD_W'(sx) * PROD_W'(sy);
      term = {{EXT_W{prod[PROD_W-1]}}, prod};
   end
endmodule

// File: rtl/mac40_wide_mult.sv
module mac40_wide_mult #(
   parameter int OP_W    = 32,
   parameter int ACC_W   = 40,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_en,
   input  logic [OP_W-1:0]  mul_x,
   input  logic [OP_W-1:0]  mul_y,
   output logic [ACC_W-1:0] term
);
   localparam int FULL_W = 2 * OP_W;

   if (ACC_W > FULL_W || ACC_W <= OP_W) begin : g_bad_width
      $error("mac40_wide_mult: ACC_W must lie in (OP_W, 2*OP_W]");
   end

   logic [FULL_W-1:0] ext_x;
   logic [FULL_W-1:0] ext_y;
   logic [FULL_W-1:0] full_prod;
   logic [ACC_W-1:0]  low_part;

   always_comb begin
      ext_x     = {{OP_W{mul_x[OP_W-1]}}, mul_x};
      ext_y     = {{OP_W{mul_y[OP_W-1]}}, mul_y};
      full_prod = ext_x * ext_y;
      low_part  = full_prod[ACC_W-1:0];
   end

   if (REG_OUT) begin : g_registered
      logic [ACC_W-1:0] term_q;
      always_ff @(posedge clk) begin
         if (rst)         term_q <= '0;
         else if (cap_en) term_q <= low_part;
      end
      assign term = term_q;
   end else begin : g_direct
      assign term = low_part;
   end
endmodule

// File: rtl/mac40_acc_core.sv
module mac40_acc_core #(
   parameter int ACC_W = 40
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             add_en,
   input  logic [ACC_W-1:0] add_term,
   input  logic             load_en,
   input  logic [ACC_W-1:0] load_val,
   output logic [ACC_W-1:0] acc
);
   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (rst)          acc_q <= '0;
      else if (load_en) acc_q <= load_val;
      else if (add_en)  acc_q <= acc_q + add_term;
   end

   assign acc = acc_q;

   AST_ACC_CLEARED: assert property (@(posedge clk)
      rst |=> (acc_q == '0)); // R1

   AST_ACC_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!add_en && !load_en) |=> $stable(acc_q)); // R9
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit #(
   parameter int OP_W     = 32,
   parameter int HALF_W   = 16,
   parameter int ACC_W    = 40,
   parameter bit WIDE_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            op_valid,
   input  logic [2:0]      op_code,
   input  logic [OP_W-1:0] src_a,
   input  logic [OP_W-1:0] src_b,
   output logic            busy,
   output logic            done,
   output logic [OP_W-1:0] rd_lo,
   output logic [OP_W-1:0] rd_hi
);
   import mac40_pkg::*;

   localparam int N_LANES = 2;
   localparam int TOP_W   = ACC_W - OP_W;
   localparam int SEXT_W  = OP_W - TOP_W;

   if (OP_W != 2 * HALF_W) begin : g_bad_half
      $error("mac40_unit: OP_W must equal 2*HALF_W");
   end
   if (ACC_W <= OP_W || ACC_W > 2 * OP_W) begin : g_bad_acc
      $error("mac40_unit: ACC_W must lie in (OP_W, 2*OP_W]");
   end

   logic             accept;
   logic             is_half, is_dual, is_wide, is_load, is_store;
   logic             busy_q, done_q;
   logic [OP_W-1:0]  rd_lo_q, rd_hi_q;
   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] wide_term;
   logic [ACC_W-1:0] add_term;
   logic             add_en;
   logic             wide_start;

   logic [HALF_W-1:0] a_hi, a_lo, b_hi, b_lo;
   logic [HALF_W-1:0] lane_x [N_LANES];
   logic [HALF_W-1:0] lane_y [N_LANES];
   logic [ACC_W-1:0]  lane_t [N_LANES];

   always_comb begin
      accept   = op_valid && !busy_q;
      is_half  = opc_is_half(op_code);
      is_dual  = (op_code == OPC_DUAL);
      is_wide  = (op_code == OPC_WIDE);
      is_load  = (op_code == OPC_LOAD);
      is_store = (op_code == OPC_STORE);
      a_hi     = src_a[OP_W-1:HALF_W];
      a_lo     = src_a[HALF_W-1:0];
      b_hi     = src_b[OP_W-1:HALF_W];
      b_lo     = src_b[HALF_W-1:0];
      // lane 0 carries the selected halves (or the low pair when dual)
      lane_x[0] = (is_half && op_code[1]) ? a_hi : a_lo;
      lane_y[0] = (is_half && op_code[0]) ? b_hi : b_lo;
      lane_x[1] = a_hi;
      lane_y[1] = b_hi;
   end

   for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
      mac40_lane_mult #(
         .HALF_W (HALF_W),
         .ACC_W  (ACC_W)
      ) u_lane (
         .mul_x (lane_x[ln]),
         .mul_y (lane_y[ln]),
         .term  (lane_t[ln])
      );
   end

   assign wide_start = accept && is_wide;

   mac40_wide_mult #(
      .OP_W    (OP_W),
      .ACC_W   (ACC_W),
      .REG_OUT (WIDE_REG)
   ) u_wide (
      .clk    (clk),
      .rst    (rst),
      .cap_en (wide_start),
      .mul_x  (src_a),
      .mul_y  (src_b),
      .term   (wide_term)
   );

   if (WIDE_REG) begin : g_two_cycle
      always_comb begin
         add_en = busy_q || (accept && (is_half || is_dual));
         if (busy_q)       add_term = wide_term;
         else if (is_dual) add_term = lane_t[0] + lane_t[1];
         else              add_term = lane_t[0];
      end
      always_ff @(posedge clk) begin
         if (rst) busy_q <= 1'b0;
         else     busy_q <= wide_start;
      end
   end else begin : g_one_cycle
      always_comb begin
         add_en = accept && (is_half || is_dual || is_wide);
         if (is_wide)      add_term = wide_term;
         else if (is_dual) add_term = lane_t[0] + lane_t[1];
         else              add_term = lane_t[0];
      end
      assign busy_q = 1'b0;
   end

   mac40_acc_core #(
      .ACC_W (ACC_W)
   ) u_acc (
      .clk      (clk),
      .rst      (rst),
      .add_en   (add_en),
      .add_term (add_term),
      .load_en  (accept && is_load),
      .load_val ({src_b[TOP_W-1:0], src_a}),
      .acc      (acc)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         done_q  <= 1'b0;
         rd_lo_q <= '0;
         rd_hi_q <= '0;
      end else begin
         done_q <= add_en || (accept && (is_load || is_store));
         if (accept && is_store) begin
            rd_lo_q <= acc[OP_W-1:0];
            rd_hi_q <= {{SEXT_W{acc[ACC_W-1]}}, acc[ACC_W-1:OP_W]};
         end
      end
   end

   assign busy  = busy_q;
   assign done  = done_q;
   assign rd_lo = rd_lo_q;
   assign rd_hi = rd_hi_q;

   AST_READ_PORT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !(op_valid && !busy && op_code == OPC_STORE) |=> ($stable(rd_lo) && $stable(rd_hi))); // R6

   AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
      (!op_valid && !busy) |=> !done); // R10

   if (WIDE_REG) begin : g_wide_checks
      AST_WIDE_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
         (op_valid && !busy && op_code == OPC_WIDE) |=> busy); // R4
      AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
         busy |=> (!busy && done)); // R8
   end
endmodule

// File: tb/sim_mac40_unit.sv
module sim_mac40_unit;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG_CYC = 150000;

   logic        clk = 1'b0;
   logic        rst;
   logic        op_valid;
   logic [2:0]  op_code;
   logic [31:0] src_a, src_b;
   logic        busy, done;
   logic [31:0] rd_lo, rd_hi;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;
   logic [39:0] acc_m;

   always #(CLK_PERIOD/2) clk = ~clk;

   mac40_unit u0 (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
      .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
      .rd_lo(rd_lo), .rd_hi(rd_hi)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [39:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [39:0] acc);
      logic [15:0] ah, bh;
      longint p, q;
      case (op)
         3'd0, 3'd1, 3'd2, 3'd3: begin
            ah = op[1] ? a[31:16] : a[15:0];
            bh = op[0] ? b[31:16] : b[15:0];
            p  = longint'($signed(ah)) * longint'($signed(bh));
            return acc + p[39:0];
         end
         3'd4: begin
            p = longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
            q = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
            return acc + p[39:0] + q[39:0];
         end
         3'd5: begin
            p = longint'($signed(a)) * longint'($signed(b));
            return acc + p[39:0];
         end
         3'd6: return {b[7:0], a};
         default: return acc;
      endcase
   endfunction

   // issue one operation; checks done timing (R10) and busy (R4)
   task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input string req);
      @(negedge clk);
      op_valid = 1'b1; op_code = op; src_a = a; src_b = b;
      @(negedge clk);
      op_valid = 1'b0;
      src_a = ~a; src_b = ~b;
      if (op == 3'd5) begin
         check({req, " R4 busy"}, {63'd0, busy}, 64'd1);
         check({req, " R10 no early done"}, {63'd0, done}, 64'd0);
         @(negedge clk);
      end
      check({req, " R10 done"}, {63'd0, done}, 64'd1);
      acc_m = model(op, a, b, acc_m);
   endtask

   task automatic readback(input string req);
      issue(3'd7, 32'h0, 32'h0, req);
      check({req, " R6 lo"}, {32'd0, rd_lo}, {32'd0, acc_m[31:0]});
      check({req, " R6 hi"}, {32'd0, rd_hi}, {32'd0, {{24{acc_m[39]}}, acc_m[39:32]}});
   endtask

   logic [31:0] vals [7];

   initial begin
      vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
      vals[3] = 32'h7FFF_8000; vals[4] = 32'h8000_7FFF; vals[5] = 32'h1234_5678;
      vals[6] = 32'hDEAD_BEEF;
      rst = 1'b1; op_valid = 1'b0; op_code = 3'd0; src_a = '0; src_b = '0;
      acc_m = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 busy", {63'd0, busy}, 64'd0);
      check("R1 done", {63'd0, done}, 64'd0);
      check("R1 rd_lo", {32'd0, rd_lo}, 64'd0);
      check("R1 rd_hi", {32'd0, rd_hi}, 64'd0);
      rst = 1'b0;
      readback("R1 acc");

      // R2 R3 R4 R5: every multiply code over all operand pairs
      for (int i = 0; i < 7; i++) begin
         for (int j = 0; j < 7; j++) begin
            for (int op = 0; op < 6; op++) begin
               issue(3'd6, vals[i] ^ vals[j], {24'd0, vals[i][7:0] ^ vals[j][15:8]}, "R5 load");
               issue(3'(op), vals[i], vals[j], op < 4 ? "R2" : (op == 4 ? "R3" : "R4"));
               readback(op < 4 ? "R2" : (op == 4 ? "R3" : "R4"));
            end
         end
      end

      // R5: upper register bits above 7 are dropped
      issue(3'd6, 32'hCAFE_0001, 32'hFFFF_FF80, "R5");
      readback("R5");
      check("R5 hi sign", {32'd0, rd_hi}, 64'h0000_0000_FFFF_FF80);

      // R7: wrap across 2^40
      issue(3'd6, 32'hFFFF_FFFF, 32'h0000_007F, "R7");
      issue(3'd0, 32'h0000_0001, 32'h0000_0001, "R7");
      readback("R7");
      check("R7 wrap hi", {32'd0, rd_hi}, 64'h0000_0000_FFFF_FF80);
      check("R7 wrap lo", {32'd0, rd_lo}, 64'd0);
      issue(3'd6, 32'hFFFF_FFFF, 32'h0000_00FF, "R7");
      issue(3'd3, 32'h0001_0000, 32'h0001_0000, "R7");
      readback("R7 to zero");
      check("R7 zero", {32'd0, rd_lo}, 64'd0);

      // R8: strobe held during busy with a load that would clobber the accumulator
      issue(3'd6, 32'h0000_0010, 32'h0, "R8 base");
      @(negedge clk);
      op_valid = 1'b1; op_code = 3'd5; src_a = 32'h0001_0003; src_b = 32'hFFFF_FFFE;
      @(negedge clk);
      check("R8 busy", {63'd0, busy}, 64'd1);
      op_code = 3'd6; src_a = 32'h5555_5555; src_b = 32'h55;
      @(negedge clk);
      op_valid = 1'b0;
      check("R8 done", {63'd0, done}, 64'd1);
      acc_m = model(3'd5, 32'h0001_0003, 32'hFFFF_FFFE, acc_m);
      @(negedge clk);
      check("R8 no second done", {63'd0, done}, 64'd0);
      readback("R8");

      // R9: idle cycles with changing operands
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         op_code = 3'(k); src_a = vals[k]; src_b = vals[6-k];
         check("R9 idle done", {63'd0, done}, 64'd0);
         check("R9 rd_lo hold", {32'd0, rd_lo}, {32'd0, acc_m[31:0]});
      end
      readback("R9 acc hold");

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule